// File: doc/BRIEF.md
# Floating-Point Status and Trap Update Unit

This block holds the floating-point status word of a processor core and updates it once for every completed floating-point operation. The execution pipeline hands over, on a single-cycle strobe, the exception flags the operation raised, the operation's class, and for compares the two-bit condition code with its destination field index. The unit masks the flags with the trap-enable field. Then it either records them in the current and accrued exception fields, or selects one trap cause by fixed priority and raises a one-cycle trap request.

The unit also supplies the effective rounding mode for the operation in flight. The interval rounding from the graphics status inputs overrides the status word's own rounding field, and float-to-integer conversions always round toward zero. Software can overwrite the whole status word through a plain write port. Operations arrive as strobes with no back-pressure: the unit accepts one on every cycle.

Status word layout (25 bits): [4:0] current exceptions, [9:5] accrued exceptions, [17:10] four 2-bit condition fields (field k at bits 10+2k), [22:18] trap enables, [24:23] rounding mode. Within each 5-bit flag group, bit 4 is invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact. Rounding codes are 0 nearest, 1 toward zero, 2 toward +inf and 3 toward -inf. Operation class codes are 0 arithmetic, 1 compare, 2 float-to-integer and 3 arithmetic.

Top module: `fpstat_unit`

## Requirements
- R1: A synchronous active-high reset clears the status word to zero, drives trap_req low and drives trap_cause to 0.
- R2: When wr_en is high at a clock edge, the status word takes wr_data in full at that edge.
- R3: A strobe whose flags AND the enable field are zero replaces the current field with the flags, ORs the flags into the accrued field, and raises no trap.
- R4: A strobe with an enabled flag sets trap_req for exactly the following cycle. trap_cause then carries the highest-priority enabled cause, with invalid first, then overflow, underflow, divide-by-zero and inexact last, coded 1, 2, 3, 4 and 5.
- R5: On a trap the current field holds only the bit of the chosen cause, and the accrued field keeps its previous value.
- R6: A compare-class strobe without a trap writes cmp_cc into condition field cmp_dst[1:0] and leaves the other three fields unchanged.
- R7: A compare-class strobe that traps writes no condition field.
- R8: eff_rnd equals gsr_rnd when gsr_interval is high, and the status rounding field otherwise. When op_kind is 2 (float-to-integer), eff_rnd is 1 (toward zero) in every case.
- R9: When wr_en and op_strobe are high together, the write is applied and the operation is dropped: it causes no status change beyond the write and raises no trap.
- R10: In a cycle with neither strobe nor write, the status word holds its value, trap_req is low and trap_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_strobe | input | 1 | One completed operation this cycle |
| op_kind | input | 2 | Operation class: 0 arith, 1 compare, 2 float-to-int, 3 arith |
| exc_flags | input | 5 | Raised exception flags of the operation |
| cmp_cc | input | 2 | Compare condition code |
| cmp_dst | input | 5 | Compare destination field; low two bits select the condition field |
| gsr_interval | input | 1 | Interval rounding override enable |
| gsr_rnd | input | 2 | Interval rounding mode |
| wr_en | input | 1 | Software write of the status word |
| wr_data | input | 25 | Status word value to write |
| status | output | 25 | Current status word |
| eff_rnd | output | 2 | Effective rounding mode for the operation in flight |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 3 | Encoded trap cause, 0 when no trap |

## Verification
A software write and an operation strobe can land in the same cycle, and the outcome then rests on the write taking precedence. The bench provokes this collision with enabled flags present, so that a wrongly accepted operation would show up as a spurious trap or as altered exception fields. A trap decision and a compare can also coincide. The reference model judges every cycle against the written word, the trap pulse and the untouched condition fields.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int NFLAG   = 5;
  localparam int NFCC    = 4;
  localparam int CCW     = 2;
  localparam int RNDW    = 2;
  localparam int CAUSEW  = 3;
  localparam int CEXC_LO = 0;
  localparam int AEXC_LO = CEXC_LO + NFLAG;
  localparam int FCC_LO  = AEXC_LO + NFLAG;
  localparam int TEM_LO  = FCC_LO + NFCC * CCW;
  localparam int RND_LO  = TEM_LO + NFLAG;
  localparam int SW      = RND_LO + RNDW;
  localparam int DSTW    = 5;

  typedef enum logic [1:0] {
    KIND_ARITH = 2'd0,
    KIND_CMP   = 2'd1,
    KIND_F2I   = 2'd2,
    KIND_ARTH2 = 2'd3
  } op_kind_e;

  localparam logic [RNDW-1:0] RND_ZERO = 2'd1;
endpackage

// File: rtl/fpstat_prio.sv
module fpstat_prio
  import fpstat_pkg::*;
(
  input  logic [NFLAG-1:0]  hit,
  output logic [CAUSEW-1:0] cause,
  output logic [NFLAG-1:0]  sel
);
  // higher bit index wins; cause code counts down from the top bit
  always_comb begin
    cause = '0;
    sel   = '0;
    for (int i = 0; i < NFLAG; i++) begin
      if (hit[i]) begin
        cause = CAUSEW'(NFLAG - i);
        sel   = NFLAG'(1) << i;
      end
    end
  end
endmodule

// File: rtl/fpstat_rnd.sv
module fpstat_rnd
  import fpstat_pkg::*;
(
  input  logic [1:0]      kind,
  input  logic            gsr_interval,
  input  logic [RNDW-1:0] gsr_rnd,
  input  logic [RNDW-1:0] word_rnd,
  output logic [RNDW-1:0] eff_rnd
);
  always_comb begin
    if (kind == KIND_F2I)  eff_rnd = RND_ZERO;
    else if (gsr_interval) eff_rnd = gsr_rnd;
    else                   eff_rnd = word_rnd;
  end
endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit
  import fpstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_strobe,
  input  logic [1:0]        op_kind,
  input  logic [NFLAG-1:0]  exc_flags,
  input  logic [CCW-1:0]    cmp_cc,
  input  logic [DSTW-1:0]   cmp_dst,
  input  logic              gsr_interval,
  input  logic [RNDW-1:0]   gsr_rnd,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_data,
  output logic [SW-1:0]     status,
  output logic [RNDW-1:0]   eff_rnd,
  output logic              trap_req,
  output logic [CAUSEW-1:0] trap_cause
);
  logic [SW-1:0]     word_q, word_nx;
  logic [NFLAG-1:0]  armed, pick;
  logic [CAUSEW-1:0] pick_code;
  logic              fire;
  logic [1:0]        slot;

  assign armed = exc_flags & word_q[TEM_LO +: NFLAG];
  assign fire  = |armed;
  assign slot  = cmp_dst[1:0];

  fpstat_prio u_prio (
    .hit   (armed),
    .cause (pick_code),
    .sel   (pick)
  );

  fpstat_rnd u_rnd (
    .kind         (op_kind),
    .gsr_interval (gsr_interval),
    .gsr_rnd      (gsr_rnd),
    .word_rnd     (word_q[RND_LO +: RNDW]),
    .eff_rnd      (eff_rnd)
  );

  always_comb begin
    word_nx = word_q;
    if (fire) begin
      word_nx[CEXC_LO +: NFLAG] = pick;
    end else begin
      word_nx[CEXC_LO +: NFLAG] = exc_flags;
      word_nx[AEXC_LO +: NFLAG] = word_q[AEXC_LO +: NFLAG] | exc_flags;
      if (op_kind == KIND_CMP) begin
        for (int k = 0; k < NFCC; k++) begin
          if (slot == 2'(k)) word_nx[FCC_LO + CCW*k +: CCW] = cmp_cc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
      if (wr_en) begin
        word_q <= wr_data;
      end else if (op_strobe) begin
        word_q     <= word_nx;
        trap_req   <= fire;
        trap_cause <= fire ? pick_code : '0;
      end
    end
  end

  assign status = word_q;
endmodule

// File: rtl/fpstat_chk.sv
module fpstat_chk
  import fpstat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              op_strobe,
  input logic [1:0]        op_kind,
  input logic              wr_en,
  input logic [SW-1:0]     wr_data,
  input logic [SW-1:0]     status,
  input logic [RNDW-1:0]   eff_rnd,
  input logic              trap_req,
  input logic [CAUSEW-1:0] trap_cause
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (status == '0 && !trap_req)); // R1
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst) wr_en |=> status == $past(wr_data)); // R2
  AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (rst) (live && trap_req) |-> $past(op_strobe && !wr_en)); // R4
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (rst) trap_req |-> (trap_cause >= 3'd1 && trap_cause <= 3'd5)); // R4
  AST_TRAP_CEXC: assert property (@(posedge clk) disable iff (rst) trap_req |-> $onehot(status[CEXC_LO +: NFLAG])); // R5
  AST_TRAP_AEXC: assert property (@(posedge clk) disable iff (rst) (live && trap_req) |-> $stable(status[AEXC_LO +: NFLAG])); // R5
  AST_TRAP_FCC: assert property (@(posedge clk) disable iff (rst) (live && trap_req) |-> $stable(status[FCC_LO +: NFCC*CCW])); // R7
  AST_F2I_ZERO: assert property (@(posedge clk) disable iff (rst) op_kind == KIND_F2I |-> eff_rnd == RND_ZERO); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (live && !$past(wr_en) && !$past(op_strobe)) |-> ($stable(status) && !trap_req)); // R10
  AST_NO_CAUSE: assert property (@(posedge clk) disable iff (rst) !trap_req |-> trap_cause == '0); // R10
endmodule

bind fpstat_unit fpstat_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_strobe  (op_strobe),
  .op_kind    (op_kind),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .status     (status),
  .eff_rnd    (eff_rnd),
  .trap_req   (trap_req),
  .trap_cause (trap_cause)
);

// File: tb/sim_fpstat_unit.sv
module sim_fpstat_unit;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_strobe = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [4:0]  exc_flags = '0;
  logic [1:0]  cmp_cc = '0;
  logic [4:0]  cmp_dst = '0;
  logic        gsr_interval = 1'b0;
  logic [1:0]  gsr_rnd = '0;
  logic        wr_en = 1'b0;
  logic [24:0] wr_data = '0;
  logic [24:0] status;
  logic [1:0]  eff_rnd;
  logic        trap_req;
  logic [2:0]  trap_cause;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference model state
  int m_cexc, m_aexc, m_tem, m_rnd;
  int m_fcc[4];
  int m_trap, m_cause;

  always #(CLK_NS/2) clk = ~clk;

  fpstat_unit u0 (
    .clk(clk), .rst(rst), .op_strobe(op_strobe), .op_kind(op_kind),
    .exc_flags(exc_flags), .cmp_cc(cmp_cc), .cmp_dst(cmp_dst),
    .gsr_interval(gsr_interval), .gsr_rnd(gsr_rnd), .wr_en(wr_en),
    .wr_data(wr_data), .status(status), .eff_rnd(eff_rnd),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  function automatic logic [24:0] model_word();
    logic [24:0] w;
    w = '0;
    w[4:0]   = 5'(m_cexc);
    w[9:5]   = 5'(m_aexc);
    for (int k = 0; k < 4; k++) w[10+2*k +: 2] = 2'(m_fcc[k]);
    w[22:18] = 5'(m_tem);
    w[24:23] = 2'(m_rnd);
    return w;
  endfunction

  task automatic model_reset();
    m_cexc = 0; m_aexc = 0; m_tem = 0; m_rnd = 0;
    for (int k = 0; k < 4; k++) m_fcc[k] = 0;
    m_trap = 0; m_cause = 0;
  endtask

  task automatic model_step(input bit stb, input int kind, input int fl,
                            input int cc, input int dst, input bit we,
                            input logic [24:0] wd);
    int en;
    m_trap = 0; m_cause = 0;
    if (we) begin
      m_cexc = int'(wd[4:0]); m_aexc = int'(wd[9:5]);
      for (int k = 0; k < 4; k++) m_fcc[k] = int'(wd[10+2*k +: 2]);
      m_tem = int'(wd[22:18]); m_rnd = int'(wd[24:23]);
    end else if (stb) begin
      en = fl & m_tem;
      if (en != 0) begin
        m_trap = 1;
        if (en & 16)      begin m_cause = 1; m_cexc = 16; end
        else if (en & 8)  begin m_cause = 2; m_cexc = 8;  end
        else if (en & 4)  begin m_cause = 3; m_cexc = 4;  end
        else if (en & 2)  begin m_cause = 4; m_cexc = 2;  end
        else              begin m_cause = 5; m_cexc = 1;  end
      end else begin
        m_cexc = fl;
        m_aexc = m_aexc | fl;
        if (kind == 1) m_fcc[dst % 4] = cc;
      end
    end
  endtask

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit stb, input int kind,
                     input int fl, input int cc, input int dst,
                     input bit we, input logic [24:0] wd,
                     input bit giv, input int grnd);
    int exp_rnd;
    @(negedge clk);
    op_strobe = stb; op_kind = 2'(kind); exc_flags = 5'(fl);
    cmp_cc = 2'(cc); cmp_dst = 5'(dst); wr_en = we; wr_data = wd;
    gsr_interval = giv; gsr_rnd = 2'(grnd);
    #1;
    exp_rnd = (kind == 2) ? 1 : (giv ? grnd : m_rnd);
    check("R8", "eff_rnd", int'(eff_rnd), exp_rnd);
    @(posedge clk);
    model_step(stb, kind, fl, cc, dst, we, wd);
    #1;
    check(tag, "status", int'(status), int'(model_word()));
    check(tag, "trap_req", int'(trap_req), m_trap);
    check(tag, "trap_cause", int'(trap_cause), m_cause);
  endtask

  function automatic logic [24:0] mkword(input int rnd, input int tem);
    logic [24:0] w;
    w = '0;
    w[24:23] = 2'(rnd);
    w[22:18] = 5'(tem);
    return w;
  endfunction

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "status", int'(status), 0);
    check("R1", "trap_req", int'(trap_req), 0);
    check("R1", "trap_cause", int'(trap_cause), 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 load word: rounding +inf, no enables, some accrued bits
    cyc("R2", 0, 0, 0, 0, 0, 1, mkword(2, 0) | 25'h00060, 0, 0);
    // R3 untrapped flag recording
    cyc("R3", 1, 0, 5'b10101, 0, 0, 0, '0, 0, 0);
    cyc("R3", 1, 3, 5'b00010, 0, 0, 0, '0, 0, 0);
    // R6 compares without trap into fields 3 and 0
    cyc("R6", 1, 1, 0, 2, 3, 0, '0, 0, 0);
    cyc("R6", 1, 1, 5'b00001, 1, 4, 0, '0, 0, 0);
    // R10 idle
    cyc("R10", 0, 1, 5'b11111, 3, 1, 0, '0, 0, 0);
    // enable all traps
    cyc("R2", 0, 0, 0, 0, 0, 1, mkword(3, 5'b11111) | 25'h003e0, 0, 0);
    // R4 / R5 priority cases
    cyc("R4", 1, 0, 5'b01010, 0, 0, 0, '0, 0, 0);
    cyc("R4", 1, 0, 5'b11111, 0, 0, 0, '0, 0, 0);
    cyc("R5", 1, 0, 5'b00001, 0, 0, 0, '0, 0, 0);
    cyc("R5", 1, 0, 5'b00110, 0, 0, 0, '0, 0, 0);
    // R7 trapping compare leaves fields
    cyc("R7", 1, 1, 5'b00100, 3, 2, 0, '0, 0, 0);
    // R8 rounding selection
    cyc("R8", 0, 0, 0, 0, 0, 0, '0, 1, 2);
    cyc("R8", 1, 2, 0, 0, 0, 0, '0, 1, 3);
    // R9 write and strobe collide with enabled flags
    cyc("R9", 1, 1, 5'b11111, 2, 1, 1, mkword(0, 5'b01000), 0, 0);
    cyc("R9", 1, 0, 5'b01000, 0, 0, 1, mkword(1, 5'b00000) | 25'h00015, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, '0, 0, 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [24:0] wd;
      r  = $urandom;
      wd = 25'($urandom);
      cyc("R3", r[0] | r[1], int'(r[3:2]), (r[4] ? int'(r[9:5]) : 0),
          int'(r[11:10]), int'(r[16:12]), (r[20:17] == 0), wd,
          r[21], int'(r[23:22]));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule